// File: doc/BRIEF.md
# Programmable Event Timer Channel

This block is one channel of a set of 16-bit up-counters that share a register port. Each channel holds a count, a compare value and a control word. On every step of its selected source the count moves up by one. It can either fold back to zero when it meets the compare value or run all the way round past 0xFFFF. Events on the compare value and on the wrap can raise a one-cycle interrupt request. The request can be one-shot, re-armed by a control write, or it can repeat. Sticky event flags in the control word are cleared by reading it.

The parameter `KIND` picks the channel flavour. It decides what control bits 8, 9 and 0 mean for the count source:

- KIND 0 can step on a pixel-rate strobe.
- KIND 1 can step on a line-rate strobe.
- KIND 2 can step on the system clock divided by eight, or stop altogether.

Both source strobes are single-cycle enables that are synchronous to `clk`. Registers are selected by `reg_sel`: 0 for the count, 1 for the control word, 2 for the compare value. A read returns the value combinationally on `rd_data`.

Top module: `evt_timer_channel`

## Requirements
- R1: While reset is held, the count, control word and compare value all read 0, and irq is low.
- R2: With control bits 0, 8 and 9 clear, the count rises by one on every clock edge.
- R3: With control bit 3 set, a step whose result would equal the compare value loads 0 instead. With bit 3 clear, the count passes the compare value unchanged and wraps from 0xFFFF to 0.
- R4: irq goes high for exactly one cycle, at the same edge that performs the step. This happens when the step meets the compare value with control bit 4 set, or wraps with control bit 5 set. No other step raises irq.
- R5: With control bit 6 clear, only the first qualifying event after a control write raises irq. With bit 6 set, every qualifying event raises irq.
- R6: A compare event sets control bits 10 and 11, and a wrap event sets bits 10 and 12, whatever bits 4 and 5 hold. A read of the control word (rd_en with reg_sel=1) returns the current value and clears bits 11 and 12 at that edge, unless an event sets them at the same edge.
- R7: A control write zeroes the count, clears the one-shot state and stores bits 10..0 of the written data. Bits 11 and 12 become 0, and bits 15..13 always read 0.
- R8: A compare-value write leaves the count at its value for that edge. A count write loads the written value in place of any step.
- R9: With control bit 8 set, a KIND 0 channel steps only on cycles with dot_tick high, and a KIND 1 channel steps only on cycles with hsync_tick high.
- R10: On a KIND 2 channel, control bit 9 makes the count step once per 8 clocks. The first step comes on the 8th edge after the control write, because the prescaler is cleared by that write. Control bit 0 stops the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 control, 2 compare |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; clears the sticky flags when the control word is selected |
| rd_data | output | 16 | Selected register value |
| dot_tick | input | 1 | Pixel-rate step strobe (KIND 0) |
| hsync_tick | input | 1 | Line-rate step strobe (KIND 1) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is a second qualifying event in one-shot mode. Proving silence needs a channel that has already fired once, with no control write in between. The stimulus sets a small compare value with fold-back enabled and lets the count pass through the compare point twice. It then checks that irq stays low on the second pass. After that, the same sequence is repeated with repeat mode on. Wrap events are reached by loading 0xFFFD through the count register rather than waiting 65536 cycles.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int unsigned REG_W     = 16;
    localparam int unsigned B_STOP    = 0;
    localparam int unsigned B_FOLD    = 3;
    localparam int unsigned B_IRQ_CMP = 4;
    localparam int unsigned B_IRQ_WRP = 5;
    localparam int unsigned B_REPEAT  = 6;
    localparam int unsigned B_SRC_A   = 8;
    localparam int unsigned B_SRC_B   = 9;
    localparam int unsigned B_EVENT   = 10;
    localparam int unsigned B_HIT_CMP = 11;
    localparam int unsigned B_HIT_WRP = 12;
    localparam int unsigned KEEP_W    = 11;

    localparam int KIND_DOT   = 0;
    localparam int KIND_HSYNC = 1;
    localparam int KIND_DIV   = 2;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_CMP   = 2'd2,
        SEL_NONE  = 2'd3
    } rc_sel_e;
endpackage

// File: rtl/rc_src_sel.sv
module rc_src_sel #(
    parameter int KIND  = 0,
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic src_a,
    input  logic src_b,
    input  logic stop,
    input  logic dot_tick,
    input  logic hsync_tick,
    output logic step
);
    generate
        if (KIND == rc_pkg::KIND_DIV) begin : g_div
            logic [PRE_W-1:0] pre_d, pre_q;
            logic unused_in;
            assign unused_in = &{1'b0, src_a, dot_tick, hsync_tick};

            always_comb begin
                pre_d = ctrl_wr ? '0 : pre_q + 1'b1;
                step  = !stop && (src_b ? (&pre_q) : 1'b1);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end
        end else if (KIND == rc_pkg::KIND_HSYNC) begin : g_line
            logic unused_in;
            assign unused_in = &{1'b0, clk, rst_n, ctrl_wr, src_b, stop, dot_tick};
            always_comb step = src_a ? hsync_tick : 1'b1;
        end else begin : g_dot
            logic unused_in;
            assign unused_in = &{1'b0, clk, rst_n, ctrl_wr, src_b, stop, hsync_tick};
            always_comb step = src_a ? dot_tick : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rc_counter.sv
module rc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic         load,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  logic         fold,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_val,
    output logic         cmp_evt,
    output logic         wrap_evt
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmp;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W-1:0] inc;
    logic         live;

    always_comb begin
        st_d     = st_q;
        inc      = st_q.cnt + 1'b1;
        live     = step && !clr && !load && !cmp_wr;
        cmp_evt  = live && (inc == st_q.cmp);
        wrap_evt = live && (&st_q.cnt);
        if (clr) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = wdata;
        end else if (cmp_wr) begin
            st_d.cmp = wdata;
        end else if (live) begin
            st_d.cnt = (cmp_evt && fold) ? '0 : inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign cmp_val = st_q.cmp;
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import rc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic [REG_W-1:0] wdata,
    input  logic             cmp_evt,
    input  logic             wrap_evt,
    output logic [REG_W-1:0] ctrl,
    output logic             fired,
    output logic             irq
);
    typedef struct packed {
        logic [REG_W-1:0] word;
        logic             fired;
        logic             irq;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        want;
    logic        unused_hi;

    assign unused_hi = &{1'b0, wdata[REG_W-1:KEEP_W]};

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        want     = (cmp_evt && st_q.word[B_IRQ_CMP]) || (wrap_evt && st_q.word[B_IRQ_WRP]);
        if (ctrl_wr) begin
            st_d.word  = {{(REG_W-KEEP_W){1'b0}}, wdata[KEEP_W-1:0]};
            st_d.fired = 1'b0;
        end else begin
            if (ctrl_rd) begin
                st_d.word[B_HIT_CMP] = 1'b0;
                st_d.word[B_HIT_WRP] = 1'b0;
            end
            if (cmp_evt) begin
                st_d.word[B_EVENT]   = 1'b1;
                st_d.word[B_HIT_CMP] = 1'b1;
            end
            if (wrap_evt) begin
                st_d.word[B_EVENT]   = 1'b1;
                st_d.word[B_HIT_WRP] = 1'b1;
            end
            if (want && (st_q.word[B_REPEAT] || !st_q.fired)) begin
                st_d.irq   = 1'b1;
                st_d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl  = st_q.word;
    assign fired = st_q.fired;
    assign irq   = st_q.irq;
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
    import rc_pkg::*;
#(
    parameter int KIND  = 0,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             dot_tick,
    input  logic             hsync_tick,
    output logic             irq
);
    rc_sel_e          sel;
    logic             ctrl_wr, ctrl_rd, cnt_wr, cmp_wr;
    logic             step, cmp_evt, wrap_evt, fired;
    logic [REG_W-1:0] count, cmp_val, ctrl;

    assign sel     = rc_sel_e'(reg_sel);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign cnt_wr  = wr_en && (sel == SEL_COUNT);
    assign cmp_wr  = wr_en && (sel == SEL_CMP);
    assign ctrl_rd = rd_en && !wr_en && (sel == SEL_CTRL);

    rc_src_sel #(.KIND(KIND), .PRE_W(PRE_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .src_a      (ctrl[B_SRC_A]),
        .src_b      (ctrl[B_SRC_B]),
        .stop       (ctrl[B_STOP]),
        .dot_tick   (dot_tick),
        .hsync_tick (hsync_tick),
        .step       (step)
    );

    rc_counter #(.W(REG_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .clr      (ctrl_wr),
        .load     (cnt_wr),
        .cmp_wr   (cmp_wr),
        .wdata    (wr_data),
        .fold     (ctrl[B_FOLD]),
        .count    (count),
        .cmp_val  (cmp_val),
        .cmp_evt  (cmp_evt),
        .wrap_evt (wrap_evt)
    );

    rc_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_rd  (ctrl_rd),
        .wdata    (wr_data),
        .cmp_evt  (cmp_evt),
        .wrap_evt (wrap_evt),
        .ctrl     (ctrl),
        .fired    (fired),
        .irq      (irq)
    );

    always_comb begin
        case (sel)
            SEL_COUNT: rd_data = count;
            SEL_CTRL:  rd_data = ctrl;
            SEL_CMP:   rd_data = cmp_val;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/evt_timer_channel_chk.sv
module evt_timer_channel_chk #(
    parameter int KIND = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_sel,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rd_data,
    input logic [15:0] count,
    input logic [15:0] ctrl,
    input logic        fired,
    input logic        cmp_evt,
    input logic        wrap_evt,
    input logic        irq
);
    a_r7_ctrl_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1) |=> (count == 16'd0 && ctrl[12:11] == 2'b00));

    a_r7_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1) |-> (rd_data[15:13] == 3'b000));

    a_r5_one_shot_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !ctrl[6] && !(wr_en && reg_sel == 2'd1)) |=> !irq);

    a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((cmp_evt && ctrl[4]) || (wrap_evt && ctrl[5])));

    a_r6_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl[11] || ctrl[12]));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_sel == 2'd1 && !cmp_evt && !wrap_evt)
        |=> (ctrl[12:11] == 2'b00));

    a_r8_cmp_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2) |=> $stable(count));

    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == 2 && ctrl[0] && !wr_en) |=> $stable(count));
endmodule

bind evt_timer_channel evt_timer_channel_chk #(.KIND(KIND)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .count    (count),
    .ctrl     (ctrl),
    .fired    (fired),
    .cmp_evt  (cmp_evt),
    .wrap_evt (wrap_evt),
    .irq      (irq)
);

// File: tb/evt_timer_channel_tb.sv
module evt_timer_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        dot_tick = 1'b0;
    logic        hsync_tick = 1'b0;
    logic [15:0] rd0, rd1, rd2;
    logic        irq0, irq1, irq2;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    evt_timer_channel #(.KIND(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd2), .dot_tick(dot_tick), .hsync_tick(hsync_tick), .irq(irq2));

    evt_timer_channel #(.KIND(0)) u_dut_dot (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd0), .dot_tick(dot_tick), .hsync_tick(hsync_tick), .irq(irq0));

    evt_timer_channel #(.KIND(1)) u_dut_hs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd1), .dot_tick(dot_tick), .hsync_tick(hsync_tick), .irq(irq1));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] s, input int which, output logic [15:0] v);
        reg_sel = s;
        #1;
        v = (which == 0) ? rd0 : (which == 1) ? rd1 : rd2;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] v);
        reg_sel = s;
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_ctrl(output logic [15:0] v);
        reg_sel = 2'd1;
        rd_en   = 1'b1;
        #1;
        v = rd2;
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        wait_n(2);
        peek(2'd0, 2, v); chk("R1 count", v, 16'h0000);
        peek(2'd1, 2, v); chk("R1 ctrl", v, 16'h0000);
        peek(2'd2, 2, v); chk("R1 cmp", v, 16'h0000);
        chk("R1 irq", {15'd0, irq2}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_free_run();
        logic [15:0] v;
        wr_reg(2'd1, 16'h0000);
        peek(2'd0, 2, v); chk("R7 count zeroed", v, 16'd0);
        wait_n(5);
        peek(2'd0, 2, v); chk("R2 free run", v, 16'd5);
    endtask

    task automatic t_fold_one_shot();
        logic [15:0] v;
        wr_reg(2'd2, 16'd5);
        wr_reg(2'd1, 16'h0018);
        wait_n(4);
        peek(2'd0, 2, v); chk("R3 before cmp", v, 16'd4);
        chk("R4 no irq yet", {15'd0, irq2}, 16'd0);
        wait_n(1);
        peek(2'd0, 2, v); chk("R3 folded", v, 16'd0);
        chk("R4 irq on cmp", {15'd0, irq2}, 16'd1);
        wait_n(1);
        chk("R4 one cycle", {15'd0, irq2}, 16'd0);
        wait_n(4);
        peek(2'd0, 2, v); chk("R3 second fold", v, 16'd0);
        chk("R5 one shot silent", {15'd0, irq2}, 16'd0);
        rd_ctrl(v); chk("R6 flags before read", v, 16'h0C18);
        peek(2'd1, 2, v); chk("R6 cleared by read", v, 16'h0418);
    endtask

    task automatic t_repeat();
        wr_reg(2'd1, 16'h0058);
        wait_n(5);
        chk("R5 repeat first", {15'd0, irq2}, 16'd1);
        wait_n(5);
        chk("R5 repeat second", {15'd0, irq2}, 16'd1);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        wr_reg(2'd1, 16'h0020);
        wr_reg(2'd0, 16'hFFFD);
        peek(2'd0, 2, v); chk("R8 count load", v, 16'hFFFD);
        wait_n(2);
        chk("R4 no irq before wrap", {15'd0, irq2}, 16'd0);
        wait_n(1);
        peek(2'd0, 2, v); chk("R3 wrapped", v, 16'h0000);
        chk("R4 irq on wrap", {15'd0, irq2}, 16'd1);
        rd_ctrl(v); chk("R6 wrap flags", v, 16'h1420);
        peek(2'd1, 2, v); chk("R6 wrap flag cleared", v, 16'h0420);
        wait_n(4);
        peek(2'd0, 2, v); chk("R3 reaches cmp", v, 16'd5);
        chk("R4 cmp without enable", {15'd0, irq2}, 16'd0);
        wait_n(1);
        peek(2'd0, 2, v); chk("R3 passes cmp", v, 16'd6);
    endtask

    task automatic t_cmp_keep();
        logic [15:0] v;
        wr_reg(2'd1, 16'h0000);
        wait_n(3);
        wr_reg(2'd2, 16'h0100);
        peek(2'd0, 2, v); chk("R8 cmp write keeps count", v, 16'd3);
        peek(2'd2, 2, v); chk("R8 cmp stored", v, 16'h0100);
        wr_reg(2'd0, 16'h1234);
        peek(2'd0, 2, v); chk("R8 count loaded", v, 16'h1234);
    endtask

    task automatic t_sources();
        logic [15:0] v;
        wr_reg(2'd1, 16'h0100);
        wait_n(3);
        for (int i = 0; i < 3; i++) begin
            dot_tick = 1'b1;
            @(negedge clk);
            dot_tick = 1'b0;
            wait_n(1);
        end
        for (int i = 0; i < 2; i++) begin
            hsync_tick = 1'b1;
            @(negedge clk);
            hsync_tick = 1'b0;
            wait_n(2);
        end
        peek(2'd0, 0, v); chk("R9 dot source", v, 16'd3);
        peek(2'd0, 1, v); chk("R9 line source", v, 16'd2);
    endtask

    task automatic t_div8();
        logic [15:0] v;
        wr_reg(2'd1, 16'h0200);
        wait_n(7);
        peek(2'd0, 2, v); chk("R10 div before 8", v, 16'd0);
        wait_n(1);
        peek(2'd0, 2, v); chk("R10 div first step", v, 16'd1);
        wait_n(8);
        peek(2'd0, 2, v); chk("R10 div second step", v, 16'd2);
        wr_reg(2'd1, 16'h0001);
        wait_n(10);
        peek(2'd0, 2, v); chk("R10 stopped", v, 16'd0);
    endtask

    task automatic t_ctrl_bits();
        logic [15:0] v;
        wr_reg(2'd1, 16'hF800);
        peek(2'd1, 2, v); chk("R7 high bits dropped", v, 16'h0000);
        wr_reg(2'd1, 16'h0458);
        peek(2'd1, 2, v); chk("R7 low bits kept", v, 16'h0458);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_free_run();
        t_fold_one_shot();
        t_repeat();
        t_wrap();
        t_cmp_keep();
        t_sources();
        t_div8();
        t_ctrl_bits();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule